// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block decides which analog input a 12-input converter samples next, and where each result goes in result memory. A 2-bit scan mode and a 4-bit channel select are captured on a start pulse. The block then raises a conversion request that carries a channel number and a result slot. It holds that request until the converter reports completion. When the last conversion of the scan is accepted, it gives a one-cycle done pulse.

In one-shot operation the scan ends by itself. In continuous operation the block keeps converting until an abort input arrives, as when a bus master refuses a byte. The shared reference pin channel can be dropped from multichannel scans when that pin serves as a reference. The analog converter and the serial bus sit outside this block. The converter appears here only as a completion strobe.

Top module: `scan_sequencer`

## Requirements
- R1: During and after reset the block is idle. `conv_req_o`, `scan_done_o` and `wr_idx_o` are 0, and `conv_chan_o` reads channel 0, a single conversion on channel 0.
- R2: Mode 2'b00 converts channels 0, 1, ... up to the selected channel in ascending order. A selection above 11 ends the scan at channel 11.
- R3: Mode 2'b01 in one-shot operation converts the selected channel (clamped to 11) eight times in a row.
- R4: Mode 2'b10 converts channels 6 upward to the selected channel (clamped to 11). A selection of 6 or lower converts channel 6 once.
- R5: Mode 2'b11 in one-shot operation converts the selected channel (clamped to 11) exactly once.
- R6: When `ref_pin_i` is 1, channel 10 (parameter `REF_CH`) is skipped in modes 2'b00 and 2'b10 only. Modes 2'b01 and 2'b11 still convert it.
- R7: The result slot `wr_idx_o` is 0 for the first conversion after a start and rises by one per accepted conversion. After slot 11 it wraps to 0.
- R8: `conv_req_o` stays high with `conv_chan_o` and `wr_idx_o` unchanged until `conv_done_i` is sampled high. Each cycle with `conv_done_i` high accepts exactly one conversion.
- R9: `scan_done_o` is high for exactly one cycle. That cycle follows the cycle in which the final conversion was accepted, and `conv_req_o` is low in it.
- R10: With `continuous_i` high at start, modes 2'b01 and 2'b11 both repeat the selected channel, and modes 2'b00 and 2'b10 restart their sequence after its last channel. This continues until `abort_i` is sampled high. The block then goes idle and pulses `scan_done_o` in the next cycle.
- R11: A start pulse that arrives while a scan is in progress has no effect on the channels or slots issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a scan (ignored while busy) |
| scan_mode_i | input | 2 | Scan mode captured at start |
| chan_sel_i | input | 4 | Channel select captured at start |
| ref_pin_i | input | 1 | Shared pin used as reference; skip it in multichannel scans |
| continuous_i | input | 1 | Keep converting until abort |
| abort_i | input | 1 | End the current scan at once |
| conv_done_i | input | 1 | Converter finished the requested conversion |
| conv_req_o | output | 1 | Conversion requested |
| conv_chan_o | output | 4 | Channel to convert |
| wr_idx_o | output | 4 | Result memory slot for this conversion |
| scan_done_o | output | 1 | One-cycle pulse at end of scan |

## Verification
The four modes are each run with selections below, at and above their limits. This separates the upward scan with its clamp from the mid-start scan, whose low selections must collapse to channel 6.

The reference skip is tried both where it applies and in the repeat and single modes, where it must not. This separates a skip tied to scan type from one tied to the channel number.

Continuous runs longer than twelve conversions show slot wrap-around and show that the repeat and single modes behave alike. Stalled handshakes and a mid-scan start show that outputs hold and that the captured settings cannot be disturbed.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    SCAN_UP       = 2'b00,
    SCAN_REPEAT   = 2'b01,
    SCAN_FROM_MID = 2'b10,
    SCAN_SINGLE   = 2'b11
  } scan_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/scan_bounds.sv
module scan_bounds
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int MID_CH = 6,
  parameter int REF_CH = 10,
  parameter int CH_W   = 4
) (
  input  scan_mode_e      mode_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic            ref_en_i,
  output logic [CH_W-1:0] first_o,
  output logic [CH_W-1:0] last_o,
  output logic            skip_o
);
  localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0] MID    = CH_W'(MID_CH);
  localparam logic [CH_W-1:0] REFC   = CH_W'(REF_CH);

  logic [CH_W-1:0] clamp;
  logic [CH_W-1:0] base;
  logic            multi;

  always_comb begin
    clamp  = (sel_i > TOP_CH) ? TOP_CH : sel_i;
    multi  = (mode_i == SCAN_UP) || (mode_i == SCAN_FROM_MID);
    skip_o = ref_en_i & multi;
    unique case (mode_i)
      SCAN_UP: begin
        base   = '0;
        last_o = clamp;
      end
      SCAN_FROM_MID: begin
        base   = MID;
        last_o = (clamp < MID) ? MID : clamp;
      end
      default: begin
        base   = clamp;
        last_o = clamp;
      end
    endcase
    first_o = (skip_o && (base == REFC)) ? base + 1'b1 : base;
  end
endmodule

// File: rtl/scan_stepper.sv
module scan_stepper
  import scan_seq_pkg::*;
#(
  parameter int REF_CH   = 10,
  parameter int REPEAT_N = 8,
  parameter int CH_W     = 4,
  parameter int RPT_W    = 3
) (
  input  scan_mode_e       mode_i,
  input  logic             cont_i,
  input  logic             skip_i,
  input  logic [CH_W-1:0]  cur_ch_i,
  input  logic [RPT_W-1:0] rep_i,
  input  logic [CH_W-1:0]  first_i,
  input  logic [CH_W-1:0]  last_i,
  output logic [CH_W-1:0]  nxt_ch_o,
  output logic [RPT_W-1:0] nxt_rep_o,
  output logic             final_o
);
  localparam logic [CH_W:0]    REFC     = (CH_W+1)'(REF_CH);
  localparam logic [RPT_W-1:0] REP_LAST = RPT_W'(REPEAT_N - 1);

  logic [CH_W:0] inc;
  logic          wrap;
  logic          rep_full;

  always_comb begin
    inc = {1'b0, cur_ch_i} + 1'b1;
    if (skip_i && (inc == REFC)) inc = inc + 1'b1;
    wrap      = inc > {1'b0, last_i};
    rep_full  = (rep_i == REP_LAST);
    nxt_rep_o = rep_full ? '0 : rep_i + 1'b1;
    unique case (mode_i)
      SCAN_UP, SCAN_FROM_MID: begin
        nxt_ch_o = wrap ? first_i : inc[CH_W-1:0];
        final_o  = wrap & ~cont_i;
      end
      SCAN_REPEAT: begin
        nxt_ch_o = cur_ch_i;
        final_o  = rep_full & ~cont_i;
      end
      default: begin
        nxt_ch_o = cur_ch_i;
        final_o  = ~cont_i;
      end
    endcase
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int MID_CH    = 6,
  parameter int REF_CH    = 10,
  parameter int REPEAT_N  = 8,
  parameter int NUM_SLOTS = 12,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int WR_W  = $clog2(NUM_SLOTS),
  localparam int RPT_W = $clog2(REPEAT_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      scan_mode_i,
  input  logic [CH_W-1:0] chan_sel_i,
  input  logic            ref_pin_i,
  input  logic            continuous_i,
  input  logic            abort_i,
  input  logic            conv_done_i,
  output logic            conv_req_o,
  output logic [CH_W-1:0] conv_chan_o,
  output logic [WR_W-1:0] wr_idx_o,
  output logic            scan_done_o
);
  localparam logic [WR_W-1:0] LAST_SLOT = WR_W'(NUM_SLOTS - 1);
  localparam logic [CH_W-1:0] TOP_CH    = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0] REFC      = CH_W'(REF_CH);

  logic rst_q_n;
  seq_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(rst_q_n));

  seq_state_e       state_q, state_d;
  scan_mode_e       mode_q;
  logic [CH_W-1:0]  sel_q;
  logic             ref_q, cont_q;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [RPT_W-1:0] rep_q, rep_d;
  logic [WR_W-1:0]  wr_q, wr_d;
  logic             done_q, done_d;
  logic             cfg_en, busy;

  scan_mode_e       cfg_mode;
  logic [CH_W-1:0]  cfg_sel;
  logic             cfg_ref, cfg_cont;
  logic [CH_W-1:0]  first_ch, last_ch, nxt_ch;
  logic [RPT_W-1:0] nxt_rep;
  logic             skip_ref, final_conv;

  assign busy     = (state_q == ST_BUSY);
  assign cfg_mode = busy ? mode_q : scan_mode_e'(scan_mode_i);
  assign cfg_sel  = busy ? sel_q  : chan_sel_i;
  assign cfg_ref  = busy ? ref_q  : ref_pin_i;
  assign cfg_cont = busy ? cont_q : continuous_i;

  scan_bounds #(
    .NUM_CH(NUM_CH), .MID_CH(MID_CH), .REF_CH(REF_CH), .CH_W(CH_W)
  ) u_bounds (
    .mode_i(cfg_mode), .sel_i(cfg_sel), .ref_en_i(cfg_ref),
    .first_o(first_ch), .last_o(last_ch), .skip_o(skip_ref)
  );

  scan_stepper #(
    .REF_CH(REF_CH), .REPEAT_N(REPEAT_N), .CH_W(CH_W), .RPT_W(RPT_W)
  ) u_stepper (
    .mode_i(cfg_mode), .cont_i(cfg_cont), .skip_i(skip_ref),
    .cur_ch_i(chan_q), .rep_i(rep_q), .first_i(first_ch), .last_i(last_ch),
    .nxt_ch_o(nxt_ch), .nxt_rep_o(nxt_rep), .final_o(final_conv)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    rep_d   = rep_q;
    wr_d    = wr_q;
    done_d  = 1'b0;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_en  = 1'b1;
          state_d = ST_BUSY;
          chan_d  = first_ch;
          rep_d   = '0;
          wr_d    = '0;
        end
      end
      default: begin
        if (abort_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (conv_done_i) begin
          wr_d   = (wr_q == LAST_SLOT) ? '0 : wr_q + 1'b1;
          chan_d = nxt_ch;
          rep_d  = nxt_rep;
          if (final_conv) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      rep_q   <= '0;
      wr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      rep_q   <= rep_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= SCAN_SINGLE;
      sel_q  <= '0;
      ref_q  <= 1'b0;
      cont_q <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= scan_mode_e'(scan_mode_i);
      sel_q  <= chan_sel_i;
      ref_q  <= ref_pin_i;
      cont_q <= continuous_i;
    end
  end

  assign conv_req_o  = busy;
  assign conv_chan_o = chan_q;
  assign wr_idx_o    = wr_q;
  assign scan_done_o = done_q;

  // Assertions
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o && !conv_done_i && !abort_i |=>
      conv_req_o && $stable(conv_chan_o) && $stable(wr_idx_o));

  a_r2_channel_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o |-> conv_chan_o <= TOP_CH);

  a_r6_ref_skipped: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o && skip_ref |-> conv_chan_o != REFC);

  a_r7_slot_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_idx_o <= LAST_SLOT);

  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_q_n)
    scan_done_o |=> !scan_done_o);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    scan_done_o |-> !conv_req_o);

  a_r5_single_ends: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o && conv_done_i && !abort_i && mode_q == SCAN_SINGLE && !cont_q
      |=> scan_done_o && !conv_req_o);

  a_r10_abort_ends: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o && abort_i |=> !conv_req_o && scan_done_o);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_q_n)
    conv_req_o && start_i && !conv_done_i && !abort_i |=>
      conv_req_o && $stable(conv_chan_o));
endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, ref_pin_i, continuous_i, abort_i, conv_done_i;
  logic [1:0] scan_mode_i;
  logic [3:0] chan_sel_i;
  logic       conv_req_o, scan_done_o;
  logic [3:0] conv_chan_o, wr_idx_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";
  logic  stall_en = 1'b0;
  logic  allow_extra = 1'b0;
  logic  phase = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_sequencer i_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_mode_i(scan_mode_i),
    .chan_sel_i(chan_sel_i), .ref_pin_i(ref_pin_i), .continuous_i(continuous_i),
    .abort_i(abort_i), .conv_done_i(conv_done_i), .conv_req_o(conv_req_o),
    .conv_chan_o(conv_chan_o), .wr_idx_o(wr_idx_o), .scan_done_o(scan_done_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: answers requests and compares them against the scoreboard
  always @(negedge clk) begin
    if (rst_n && conv_req_o && exp_q.size() > 0) begin
      if (stall_en && !phase) begin
        conv_done_i = 1'b0;
        phase = 1'b1;
      end else begin
        logic [7:0] item;
        item = exp_q.pop_front();
        n_tests++;
        if ({conv_chan_o, wr_idx_o} !== item) begin
          n_fail++;
          $display("FAIL %s: actual chan %0d slot %0d expected chan %0d slot %0d",
                   cur_tag, conv_chan_o, wr_idx_o, item[7:4], item[3:0]);
        end
        conv_done_i = 1'b1;
        phase = 1'b0;
      end
    end else begin
      conv_done_i = 1'b0;
      if (rst_n && conv_req_o && !allow_extra) begin
        n_tests++;
        n_fail++;
        $display("FAIL %s: actual unexpected request chan %0d expected none",
                 cur_tag, conv_chan_o);
      end
    end
  end

  // Driver: builds the expected sequence from the requirements, then starts
  task automatic run_scan(input logic [1:0] m, input int s, input logic r,
                          input logic c, input int ncont, input logic stall,
                          input logic inject, input string tag);
    int pass[$];
    int items[$];
    int cl;
    int lastc;
    cl = (s > 11) ? 11 : s;
    case (m)
      2'b00: for (int ch = 0; ch <= cl; ch++) if (!(r && ch == 10)) pass.push_back(ch);
      2'b10: begin
        lastc = (cl < 6) ? 6 : cl;
        for (int ch = 6; ch <= lastc; ch++) if (!(r && ch == 10)) pass.push_back(ch);
      end
      2'b01: for (int k = 0; k < (c ? 1 : 8); k++) pass.push_back(cl);
      default: pass.push_back(cl);
    endcase
    if (!c) items = pass;
    else for (int k = 0; k < ncont; k++) items.push_back(pass[k % pass.size()]);
    for (int k = 0; k < items.size(); k++) exp_q.push_back({4'(items[k]), 4'(k % 12)});

    cur_tag = tag;
    stall_en = stall;
    allow_extra = c;
    @(negedge clk);
    scan_mode_i = m; chan_sel_i = 4'(s); ref_pin_i = r; continuous_i = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      @(negedge clk);
      start_i = 1'b1; scan_mode_i = 2'b11; chan_sel_i = 4'd3; ref_pin_i = ~r;
      @(negedge clk);
      start_i = 1'b0;
    end
    if (c) begin
      for (int k = 0; k < 500 && exp_q.size() != 0; k++) @(negedge clk);
      @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check({tag, " R10 abort done"}, int'(scan_done_o), 1);
      check({tag, " R10 idle after abort"}, int'(conv_req_o), 0);
    end else begin
      for (int k = 0; k < 500 && !scan_done_o; k++) @(negedge clk);
      check({tag, " R9 done seen"}, int'(scan_done_o), 1);
      check({tag, " R9 request low with done"}, int'(conv_req_o), 0);
    end
    check({tag, " all conversions issued"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check({tag, " R9 done one cycle"}, int'(scan_done_o), 0);
    allow_extra = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; conv_done_i = 1'b0;
    scan_mode_i = 2'b00; chan_sel_i = 4'd0; ref_pin_i = 1'b0; continuous_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(conv_req_o), 0);
    check("R1 chan in reset", int'(conv_chan_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req after reset", int'(conv_req_o), 0);
    check("R1 chan after reset", int'(conv_chan_o), 0);
    check("R1 slot after reset", int'(wr_idx_o), 0);
    check("R1 done after reset", int'(scan_done_o), 0);

    run_scan(2'b00, 4,  1'b0, 1'b0, 0,  1'b0, 1'b0, "R2 up to 4");
    run_scan(2'b00, 15, 1'b0, 1'b0, 0,  1'b1, 1'b0, "R2 R8 clamp stalled");
    run_scan(2'b00, 0,  1'b0, 1'b0, 0,  1'b0, 1'b0, "R2 only 0");
    run_scan(2'b00, 11, 1'b1, 1'b0, 0,  1'b0, 1'b0, "R6 up skip ref");
    run_scan(2'b01, 5,  1'b0, 1'b0, 0,  1'b1, 1'b0, "R3 eight of 5");
    run_scan(2'b01, 10, 1'b1, 1'b0, 0,  1'b0, 1'b0, "R3 R6 repeat keeps ref");
    run_scan(2'b10, 9,  1'b0, 1'b0, 0,  1'b0, 1'b0, "R4 mid to 9");
    run_scan(2'b10, 3,  1'b0, 1'b0, 0,  1'b0, 1'b0, "R4 low select");
    run_scan(2'b10, 12, 1'b1, 1'b0, 0,  1'b0, 1'b0, "R4 R6 mid skip ref");
    run_scan(2'b11, 7,  1'b0, 1'b0, 0,  1'b0, 1'b0, "R5 single 7");
    run_scan(2'b11, 10, 1'b1, 1'b0, 0,  1'b1, 1'b0, "R5 R6 single keeps ref");
    run_scan(2'b00, 11, 1'b0, 1'b0, 0,  1'b1, 1'b1, "R11 start while busy");
    run_scan(2'b11, 3,  1'b0, 1'b1, 15, 1'b0, 1'b0, "R10 R7 cont single wrap");
    run_scan(2'b01, 3,  1'b0, 1'b1, 15, 1'b1, 1'b0, "R10 cont repeat");
    run_scan(2'b00, 2,  1'b0, 1'b1, 7,  1'b0, 1'b0, "R10 cont up restart");
    run_scan(2'b00, 11, 1'b1, 1'b1, 14, 1'b0, 1'b0, "R7 R6 cont wrap skip");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule